// File: doc/BRIEF.md
# Read-Safe Calendar Update and Oscillator-Fail Control

This block sits between a one-second time base, the calendar counter and the host register port of a real-time clock. When a tick arrives while the host is reading one of the seven time registers (addresses 0 to 6), it holds back the calendar update. The update is not dropped: the tick is kept as a pending update and applied when the read finishes, or when a bounded wait runs out, whichever comes first. No second is lost. A read of the control register (address 7) never holds updates back. The wait is counted in pulses of a slow enable derived from the 32.768 kHz base. With the default of 8192 pulses, that is 250 ms.

The block also keeps three flag bits. The first is a sticky oscillator-fail flag, seen by the host as bit 7 of address 1. The second is the stop request, bit 7 of address 0, which feeds the oscillator. The third is the output-level bit, bit 7 of address 7, which drives an open-drain pin. The fail flag is set by reset, by a stopped oscillator and by an active stop request. A host write of 0 clears it, but only after the oscillator has run for a set number of seconds.

The control and status pins are plain levels and single-cycle pulses. There is no valid/ready handshake and no back-pressure. The calendar counter must accept one update each time `upd_strobe` is high.

Top module: `rtc_update_guard`

## Requirements
- R1: After reset, `fail_flag`=1, `out_bit`=1, `out_pull_low`=0, `stop_bit`=0 and `upd_strobe`=0.
- R2: With no time-register read in progress, a `tick_1hz` pulse sampled at clock edge k gives exactly one `upd_strobe` pulse, high in the cycle after edge k+1.
- R3: While `rd_active` is high with `rd_addr` in 0..6, and the wait has not expired, `upd_strobe` stays low.
- R4: A deferred update is issued in the cycle after the first edge at which the time-register read is no longer active.
- R5: If the read stays active, a deferred update is issued once `WAIT_CYC` `slow_en` pulses have been counted after the tick. With `slow_en` high on every cycle, the strobe is high in the cycle after edge k+`WAIT_CYC`+1, where k is the tick edge.
- R6: A read of address 7 does not defer updates. A tick then behaves as in R2.
- R7: Ticks that arrive during one deferral are all kept, up to 2^`PEND_W`-1 of them. On release they come out as the same number of strobes on consecutive cycles.
- R8: `fail_flag` is set, and held, on every edge at which `osc_running` is low or `stop_bit` is 1. It stays 1 afterwards until a clear is accepted.
- R9: A write of address 1 with bit 7 = 0 clears `fail_flag` only if `RUN_SECS` ticks have been seen with `osc_running` high since the oscillator last stopped. Otherwise the write has no effect on the flag.
- R10: A write of address 0 loads bit 7 into `stop_bit`. A write of address 7 loads bit 7 into `out_bit`, and the other data bits are ignored. `out_pull_low` equals the inverse of `out_bit`.
- R11: A write of address 1 with bit 7 = 1 sets `fail_flag` regardless of the run time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| slow_en | input | 1 | Enable pulse of the 32.768 kHz base, used to time the wait |
| rd_active | input | 1 | Host read in progress |
| rd_addr | input | 3 | Register address being read |
| osc_running | input | 1 | Oscillator currently running |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| upd_strobe | output | 1 | Advance the visible calendar by one second |
| fail_flag | output | 1 | Sticky oscillator-fail flag |
| stop_bit | output | 1 | Oscillator stop request |
| out_bit | output | 1 | Stored output-level bit |
| out_pull_low | output | 1 | Open-drain enable: pull the pin low |

## Verification
The checker tests the following on every cycle:
- no strobe follows a cycle of time-register read whose wait has not expired;
- a pending update with no read guard is released on the next edge;
- the wait counter never passes its limit;
- the fail flag is set by a stopped oscillator or an active stop request;
- the fail flag survives a clear that comes before the run time is reached.

Only the bench scenarios can show the following:
- that every tick produces exactly one strobe over long random read patterns;
- the exact release latency at the end of a read and at expiry of the wait;
- that several deferred ticks are kept;
- that the run counter restarts after an oscillator stop.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;
  typedef logic [2:0] reg_addr_t;
  localparam reg_addr_t ADDR_SECONDS = 3'd0;
  localparam reg_addr_t ADDR_MINUTES = 3'd1;
  localparam reg_addr_t ADDR_CONTROL = 3'd7;
  localparam int        FLAG_BIT     = 7;
endpackage

// File: rtl/rtc_read_hold.sv
module rtc_read_hold #(
  parameter int WAIT_CYC = 8192,
  parameter int PEND_W   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1hz,
  input  logic slow_en,
  input  logic guard,
  output logic upd_strobe,
  output logic pend_nz,
  output logic wait_done
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(WAIT_CYC);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] pend_q;
  logic [CNT_W-1:0]  wait_q;
  logic              release_w;

  assign pend_nz   = (pend_q != '0);
  assign wait_done = (wait_q == CNT_MAX);
  assign release_w = pend_nz && (!guard || wait_done);

  // pending-update counter: add ticks, subtract releases, saturate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      upd_strobe <= 1'b0;
    end else begin
      upd_strobe <= release_w;
      if (tick_1hz && !release_w) begin
        if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
      end else if (!tick_1hz && release_w) begin
        pend_q <= pend_q - 1'b1;
      end
    end
  end

  // bounded wait counter, running only while something is pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (!pend_nz) begin
      wait_q <= '0;
    end else if (slow_en && !wait_done) begin
      wait_q <= wait_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_run_timer.sv
module rtc_run_timer #(
  parameter int RUN_SECS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1hz,
  input  logic osc_running,
  output logic run_ok
);
  localparam int RUN_W = $clog2(RUN_SECS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_SECS);

  logic [RUN_W-1:0] run_q;

  assign run_ok = (run_q == RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!osc_running) begin
      run_q <= '0;
    end else if (tick_1hz && !run_ok) begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_flag_regs.sv
module rtc_flag_regs
  import rtc_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      osc_running,
  input  logic      run_ok,
  input  logic      wr_en,
  input  reg_addr_t wr_addr,
  input  logic [7:0] wr_data,
  output logic      fail_flag,
  output logic      stop_bit,
  output logic      out_bit
);
  logic wr_fail, wr_stop, wr_ctrl;

  assign wr_fail = wr_en && (wr_addr == ADDR_MINUTES);
  assign wr_stop = wr_en && (wr_addr == ADDR_SECONDS);
  assign wr_ctrl = wr_en && (wr_addr == ADDR_CONTROL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_flag <= 1'b1;
      stop_bit  <= 1'b0;
      out_bit   <= 1'b1;
    end else begin
      if (wr_stop) stop_bit <= wr_data[FLAG_BIT];
      if (wr_ctrl) out_bit  <= wr_data[FLAG_BIT];
      if (!osc_running || stop_bit) begin
        fail_flag <= 1'b1;
      end else if (wr_fail) begin
        if (wr_data[FLAG_BIT])  fail_flag <= 1'b1;
        else if (run_ok)        fail_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_update_guard.sv
module rtc_update_guard
  import rtc_guard_pkg::*;
#(
  parameter int WAIT_CYC = 8192,
  parameter int RUN_SECS = 4,
  parameter int PEND_W   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       slow_en,
  input  logic       rd_active,
  input  logic [2:0] rd_addr,
  input  logic       osc_running,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       upd_strobe,
  output logic       fail_flag,
  output logic       stop_bit,
  output logic       out_bit,
  output logic       out_pull_low
);
  logic guard, pend_nz, wait_done, run_ok;

  assign guard        = rd_active && (rd_addr != ADDR_CONTROL);
  assign out_pull_low = !out_bit;

  rtc_read_hold #(.WAIT_CYC(WAIT_CYC), .PEND_W(PEND_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .slow_en(slow_en),
    .guard(guard), .upd_strobe(upd_strobe), .pend_nz(pend_nz),
    .wait_done(wait_done)
  );

  rtc_run_timer #(.RUN_SECS(RUN_SECS)) u_run (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .osc_running(osc_running), .run_ok(run_ok)
  );

  rtc_flag_regs u_flags (
    .clk(clk), .rst_n(rst_n), .osc_running(osc_running), .run_ok(run_ok),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fail_flag(fail_flag), .stop_bit(stop_bit), .out_bit(out_bit)
  );
endmodule

// File: rtl/rtc_update_guard_chk.sv
module rtc_update_guard_chk #(
  parameter int WAIT_CYC = 8192
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_active,
  input logic [2:0] rd_addr,
  input logic       osc_running,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       upd_strobe,
  input logic       fail_flag,
  input logic       stop_bit,
  input logic       pend_nz,
  input logic       wait_done,
  input logic       run_ok,
  input logic [$clog2(WAIT_CYC+1)-1:0] wait_q
);
  // R3
  held_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && rd_addr != 3'd7 && !wait_done) |=> !upd_strobe);
  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_nz && !(rd_active && rd_addr != 3'd7)) |=> upd_strobe);
  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= ($clog2(WAIT_CYC+1))'(WAIT_CYC));
  // R8
  osc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_running || stop_bit) |=> fail_flag);
  // R9
  early_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !run_ok && wr_en && wr_addr == 3'd1 && !wr_data[7]) |=> fail_flag);
endmodule

bind rtc_update_guard rtc_update_guard_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_active(rd_active), .rd_addr(rd_addr),
  .osc_running(osc_running), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .upd_strobe(upd_strobe), .fail_flag(fail_flag),
  .stop_bit(stop_bit), .pend_nz(pend_nz), .wait_done(wait_done),
  .run_ok(run_ok), .wait_q(u_hold.wait_q)
);

// File: tb/rtc_update_guard_test.sv
module rtc_update_guard_test;
  localparam int PERIOD   = 10;
  localparam int WAIT_CYC = 8;
  localparam int RUN_SECS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0, slow_en = 1'b0, rd_active = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic osc_running = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic upd_strobe, fail_flag, stop_bit, out_bit, out_pull_low;

  int checks = 0, errors = 0, strobes = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  rtc_update_guard #(.WAIT_CYC(WAIT_CYC), .RUN_SECS(RUN_SECS), .PEND_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .slow_en(slow_en),
    .rd_active(rd_active), .rd_addr(rd_addr), .osc_running(osc_running),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_strobe(upd_strobe), .fail_flag(fail_flag), .stop_bit(stop_bit),
    .out_bit(out_bit), .out_pull_low(out_pull_low));

  always @(negedge clk) if (rst_n && upd_strobe) strobes++;

  function automatic bit is_guarded(input logic act, input logic [2:0] a);
    return act && (a < 3'd7);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic tick();
    tick_1hz = 1'b1; cyc(); tick_1hz = 1'b0;
  endtask

  task automatic write(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; cyc(); wr_en = 1'b0;
  endtask

  initial begin
    #(PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base, gap, nticks;
    void'($urandom(32'd1234));
    cyc(3); rst_n = 1'b1; #1;
    // R1 reset state
    check("R1 fail", fail_flag, 1); check("R1 out", out_bit, 1);
    check("R1 pull", out_pull_low, 0); check("R1 stop", stop_bit, 0);
    check("R1 strobe", upd_strobe, 0);
    cyc();
    // R2 plain tick
    tick(); check("R2 early", upd_strobe, 0);
    cyc(); check("R2 strobe", upd_strobe, 1);
    cyc(); check("R2 single", upd_strobe, 0);
    // R3 / R4 deferred by read, released at end of read
    rd_active = 1'b1; rd_addr = 3'd3; base = strobes;
    tick(); cyc(20);
    check("R3 held", strobes - base, 0);
    rd_active = 1'b0; cyc(); check("R4 release", upd_strobe, 1);
    cyc(); check("R4 once", strobes - base, 1);
    // R5 expiry while the read stays active
    slow_en = 1'b1; rd_active = 1'b1; rd_addr = 3'd0; base = strobes;
    tick(); cyc(WAIT_CYC);
    check("R5 not yet", strobes - base, 0); check("R5 not yet lvl", upd_strobe, 0);
    cyc(); check("R5 expired", upd_strobe, 1);
    cyc(3); rd_active = 1'b0; check("R5 once", strobes - base, 1);
    slow_en = 1'b0;
    // R6 control-register read does not defer
    rd_active = 1'b1; rd_addr = 3'd7;
    tick(); cyc(); check("R6 strobe", upd_strobe, 1);
    rd_active = 1'b0; cyc(2);
    // R7 several ticks kept
    rd_active = 1'b1; rd_addr = 3'd5; base = strobes;
    tick(); cyc(3); tick(); cyc(3); tick(); cyc(3);
    check("R7 held", strobes - base, 0);
    rd_active = 1'b0; cyc(4);
    check("R7 count", strobes - base, 3);
    // R9 clear blocked before run time
    osc_running = 1'b0; cyc(); osc_running = 1'b1; cyc();
    write(3'd1, 8'h00); check("R9 blocked", fail_flag, 1);
    repeat (RUN_SECS - 1) tick();
    write(3'd1, 8'h00); check("R9 blocked 3s", fail_flag, 1);
    tick(); write(3'd1, 8'h00); check("R9 cleared", fail_flag, 0);
    // R8 oscillator stop sets, run counter restarts
    osc_running = 1'b0; cyc(); osc_running = 1'b1;
    check("R8 stop sets", fail_flag, 1);
    write(3'd1, 8'h00); check("R9 restart blocked", fail_flag, 1);
    repeat (RUN_SECS) tick();
    write(3'd1, 8'h00); check("R9 cleared again", fail_flag, 0);
    cyc(3); check("R8 sticky zero", fail_flag, 0);
    // R10 stop bit, R8 via stop request
    write(3'd0, 8'h80); check("R10 stop", stop_bit, 1);
    cyc(); check("R8 stop request", fail_flag, 1);
    write(3'd0, 8'h7F); check("R10 stop off", stop_bit, 0);
    write(3'd1, 8'h00); check("R9 after stop", fail_flag, 0);
    // R11 host sets fail
    write(3'd1, 8'h80); check("R11 set", fail_flag, 1);
    // R10 output bit
    write(3'd7, 8'h00); check("R10 out0", out_bit, 0); check("R10 pull", out_pull_low, 1);
    write(3'd7, 8'h7F); check("R10 ignore", out_bit, 0);
    write(3'd7, 8'h80); check("R10 out1", out_bit, 1); check("R10 release", out_pull_low, 0);
    // R7/R3 random read patterns: every tick yields one strobe
    slow_en = 1'b1; base = strobes; nticks = 0; gap = 0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) rd_active = $urandom % 2;
      if ($urandom % 4 == 0) rd_addr = 3'($urandom % 8);
      gap++;
      if (gap > WAIT_CYC + 4 && $urandom % 4 == 0) begin
        tick_1hz = 1'b1; gap = 0; nticks++;
      end
      cyc(); tick_1hz = 1'b0;
      if (is_guarded(rd_active, rd_addr) && gap < WAIT_CYC && gap > 1 && upd_strobe)
        check("R3 random held", 1, 0);
    end
    rd_active = 1'b0; cyc(WAIT_CYC + 4);
    check("R7 random count", strobes - base, nticks);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule